// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Half-Bit Stop Lengths and Break

This block serialises 8-bit bytes onto a single line. Each frame has one low start bit, then eight data bits sent least significant bit first, then a stop period that is selectable in half-bit steps. A baud-tick input arrives at sixteen times the bit rate. Each bit lasts sixteen ticks, so a half bit lasts eight ticks. The line rests high between frames.

Bytes are offered on a valid/ready handshake. A byte that is offered while a frame is still being sent is taken as soon as the stop period ends, so frames can follow each other with no gap. A one-cycle request sets an internal break flag. The next frame slot then becomes a break frame: the line is held low for the whole frame and then driven high for one bit time, after which the flag clears itself. A done pulse marks the moment the line falls quiet, and an enable gates it onto an interrupt output.

The transmitter can be attached to either of two pads. The pad that is not transmitting acts as the receive input, and its level is passed through to a receive-line output for a neighbouring receiver.

Top module: `serial_tx_halfstop`

## Requirements
- R1: The stop select picks the stop period: 00 gives 1 bit (16 ticks), 01 gives 0.5 bit (8 ticks), 10 gives 2 bits (32 ticks) and 11 gives 1.5 bits (24 ticks). The value is captured when a frame starts.
- R2: While `txEnable` is 0, `txReady` stays low, no frame starts and the transmit line stays high.
- R3: A data frame is a start bit at 0 lasting 16 ticks, then 8 data bits of 16 ticks each, bit 0 first. The line is 1 at all other times outside a break.
- R4: A pulse on `breakSet` sets `breakBusy`. The break frame holds the line at 0 for 144 ticks plus the selected stop period, then at 1 for 16 ticks, and `breakBusy` returns to 0 when those 16 ticks end. A pending break starts before a waiting byte.
- R5: `txDone` pulses for one cycle after a frame's last period ends, but only if no byte is being offered and no break is pending.
- R6: `txIrq` pulses together with `txDone` when `doneIe` is 1, and stays at 0 when `doneIe` is 0.
- R7: With `swapPins` at 0, pad 0 transmits (`pad0Oe`=1, `pad1Oe`=0) and `rxLine` follows `pad1In`. With `swapPins` at 1 the two pads exchange roles. A pad that is not transmitting drives 1 with its enable at 0.
- R8: A byte offered during a frame is accepted right after that frame's stop period ends, with no `txDone` between the two frames.
- R9: `txReady` is 1 only when the block is idle, enabled and has no break pending. A byte transfers on a cycle where `txValid` and `txReady` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle strobe at 16x the bit rate |
| txEnable | input | 1 | Allows new frames to start |
| stopSel | input | 2 | Stop-length code |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte offered |
| txReady | output | 1 | Byte can be accepted |
| breakSet | input | 1 | Request a break frame |
| breakBusy | output | 1 | Break request pending or in progress |
| doneIe | input | 1 | Enables the done interrupt |
| txDone | output | 1 | Line-quiet pulse |
| txIrq | output | 1 | Gated done interrupt |
| swapPins | input | 1 | Exchanges transmit and receive pads |
| pad0In | input | 1 | Pad 0 input level |
| pad1In | input | 1 | Pad 1 input level |
| pad0Out | output | 1 | Pad 0 output value |
| pad0Oe | output | 1 | Pad 0 output enable |
| pad1Out | output | 1 | Pad 1 output value |
| pad1Oe | output | 1 | Pad 1 output enable |
| rxLine | output | 1 | Level of the pad acting as receiver |

## Verification
The bench measures the time between the start edges of back-to-back frames for each of the four stop codes. A design that mixed up the half-bit codes, or counted whole bits where it should count half bits, would give a gap off by a multiple of eight ticks. For a break frame the bench times both the low stretch and the delay from the rising edge to the flag clearing. A design that let the stop period go high, or cleared the flag at the rising edge, would give the wrong figures. Done pulses are counted across a pair of chained frames, across a single frame and across a break frame; an extra pulse between chained frames, or a missing pulse, shows up in the count. Swapped pads are checked by decoding a byte from pad 1.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BRKHI
  } txState_t;

  typedef enum logic [1:0] {
    LINE_HIGH,
    LINE_LOW,
    LINE_DATA
  } lineSel_t;

  // Strobes from control to datapath for the coming cycle
  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_t lineSel;
  } txStrobe_t;

  // Stop period length in half-bit units
  function automatic logic [2:0] stopHalves(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd2;
      2'b01:   return 3'd1;
      2'b10:   return 3'd4;
      default: return 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/stx_ctrl.sv
module stx_ctrl
  import stx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       txEnable,
  input  logic [1:0] stopSel,
  input  logic       txValid,
  input  logic       breakSet,
  output logic       txReady,
  output logic       breakBusy,
  output logic       txDone,
  output txStrobe_t  strb
);
  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam int HALF   = OVERSAMPLE / 2;
  localparam int HALF_W = $clog2(HALF);
  localparam int BIT_W  = $clog2(DATA_W);

  txState_t          stateQ, stateD;
  logic [TICK_W-1:0] tickQ;
  logic [BIT_W-1:0]  bitQ;
  logic [2:0]        halfQ;
  logic [1:0]        stopSelQ;
  logic              brkModeQ, brkModeD;
  logic              breakReqQ, doneQ;
  logic              bitEnd, halfEnd, lastHalf, accept, startBrk, frameEnd, brkEnd;
  logic [2:0]        halvesNeed;

  assign bitEnd     = baudTick && (tickQ == TICK_W'(OVERSAMPLE - 1));
  assign halfEnd    = baudTick && (tickQ[HALF_W-1:0] == HALF_W'(HALF - 1));
  assign halvesNeed = stopHalves(stopSelQ);
  assign lastHalf   = (halfQ == halvesNeed - 3'd1);
  assign txReady    = (stateQ == ST_IDLE) && txEnable && !breakReqQ;
  assign startBrk   = (stateQ == ST_IDLE) && txEnable && breakReqQ;
  assign accept     = txValid && txReady;
  assign brkEnd     = (stateQ == ST_BRKHI) && bitEnd;
  assign frameEnd   = (stateQ != ST_IDLE) && (stateD == ST_IDLE);
  assign breakBusy  = breakReqQ;
  assign txDone     = doneQ;

  always_comb begin
    stateD   = stateQ;
    brkModeD = brkModeQ;
    case (stateQ)
      ST_IDLE: begin
        if (startBrk) begin
          stateD   = ST_START;
          brkModeD = 1'b1;
        end else if (accept) begin
          stateD   = ST_START;
          brkModeD = 1'b0;
        end
      end
      ST_START: if (bitEnd) stateD = ST_DATA;
      ST_DATA:  if (bitEnd && (bitQ == BIT_W'(DATA_W - 1))) stateD = ST_STOP;
      ST_STOP:  if (halfEnd && lastHalf) stateD = brkModeQ ? ST_BRKHI : ST_IDLE;
      ST_BRKHI: if (bitEnd) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.load  = accept;
    strb.shift = (stateQ == ST_DATA) && bitEnd;
    case (stateD)
      ST_START: strb.lineSel = LINE_LOW;
      ST_DATA:  strb.lineSel = brkModeD ? LINE_LOW : LINE_DATA;
      ST_STOP:  strb.lineSel = brkModeD ? LINE_LOW : LINE_HIGH;
      default:  strb.lineSel = LINE_HIGH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      brkModeQ  <= 1'b0;
      tickQ     <= '0;
      bitQ      <= '0;
      halfQ     <= '0;
      stopSelQ  <= 2'b00;
      breakReqQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      stateQ   <= stateD;
      brkModeQ <= brkModeD;
      if (stateD != stateQ)                        tickQ <= '0;
      else if (baudTick && (stateQ != ST_IDLE))    tickQ <= tickQ + 1'b1;
      if (stateQ != ST_DATA)                       bitQ  <= '0;
      else if (bitEnd)                             bitQ  <= bitQ + 1'b1;
      if (stateQ != ST_STOP)                       halfQ <= '0;
      else if (halfEnd)                            halfQ <= halfQ + 3'd1;
      if (stateQ == ST_IDLE)                       stopSelQ <= stopSel;
      if (breakSet)                                breakReqQ <= 1'b1;
      else if (brkEnd)                             breakReqQ <= 1'b0;
      doneQ <= frameEnd && !txValid && !breakSet && !(breakReqQ && !brkEnd);
    end
  end

  a_r2_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !txEnable) |=> (stateQ == ST_IDLE));

  a_r1_stop_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STOP) |-> (halfQ < halvesNeed));

  a_r4_break_clears_after_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakReqQ) |-> ($past(stateQ) == ST_BRKHI));

  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (stateQ == ST_IDLE));

endmodule

// File: rtl/stx_dpath.sv
module stx_dpath
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              swapPins,
  input  logic              pad0In,
  input  logic              pad1In,
  output logic              pad0Out,
  output logic              pad0Oe,
  output logic              pad1Out,
  output logic              pad1Oe,
  output logic              rxLine
);
  logic [DATA_W-1:0] shiftQ, shiftNext;
  logic              txLineQ;

  always_comb begin
    if (strb.load)       shiftNext = txData;
    else if (strb.shift) shiftNext = {1'b0, shiftQ[DATA_W-1:1]};
    else                 shiftNext = shiftQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      txLineQ <= 1'b1;
    end else begin
      shiftQ <= shiftNext;
      case (strb.lineSel)
        LINE_LOW:  txLineQ <= 1'b0;
        LINE_DATA: txLineQ <= shiftNext[0];
        default:   txLineQ <= 1'b1;
      endcase
    end
  end

  // Pad routing: the idle pad drives 1 with its output enable off
  assign pad0Out = swapPins ? 1'b1 : txLineQ;
  assign pad1Out = swapPins ? txLineQ : 1'b1;
  assign pad0Oe  = !swapPins;
  assign pad1Oe  = swapPins;
  assign rxLine  = swapPins ? pad0In : pad1In;

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !txLineQ);

endmodule

// File: rtl/serial_tx_halfstop.sv
module serial_tx_halfstop
  import stx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              txEnable,
  input  logic [1:0]        stopSel,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic              breakSet,
  output logic              breakBusy,
  input  logic              doneIe,
  output logic              txDone,
  output logic              txIrq,
  input  logic              swapPins,
  input  logic              pad0In,
  input  logic              pad1In,
  output logic              pad0Out,
  output logic              pad0Oe,
  output logic              pad1Out,
  output logic              pad1Oe,
  output logic              rxLine
);
  txStrobe_t strb;

  stx_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .stopSel(stopSel), .txValid(txValid), .breakSet(breakSet),
    .txReady(txReady), .breakBusy(breakBusy), .txDone(txDone), .strb(strb)
  );

  stx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData), .swapPins(swapPins),
    .pad0In(pad0In), .pad1In(pad1In), .pad0Out(pad0Out), .pad0Oe(pad0Oe),
    .pad1Out(pad1Out), .pad1Oe(pad1Oe), .rxLine(rxLine)
  );

  assign txIrq = txDone && doneIe;

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !doneIe |-> !txIrq);

endmodule

// File: tb/serial_tx_halfstop_bench.sv
module serial_tx_halfstop_bench;
  localparam int P = 2;  // clocks per baud tick

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick;
  logic txEnable = 1'b0, txValid = 1'b0, breakSet = 1'b0, doneIe = 1'b0, swapPins = 1'b0;
  logic pad0In = 1'b1, pad1In = 1'b1;
  logic [1:0] stopSel = 2'b00;
  logic [7:0] txData = 8'h00;
  logic txReady, breakBusy, txDone, txIrq, pad0Out, pad0Oe, pad1Out, pad1Oe, rxLine;
  logic txPin;
  int divQ = 0;
  int cyc = 0;
  int doneCnt = 0, irqCnt = 0;
  int nChecks = 0, nFail = 0;

  always #5 clk = ~clk;

  serial_tx_halfstop u_serial_tx_halfstop (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable), .stopSel(stopSel),
    .txData(txData), .txValid(txValid), .txReady(txReady), .breakSet(breakSet),
    .breakBusy(breakBusy), .doneIe(doneIe), .txDone(txDone), .txIrq(txIrq),
    .swapPins(swapPins), .pad0In(pad0In), .pad1In(pad1In), .pad0Out(pad0Out),
    .pad0Oe(pad0Oe), .pad1Out(pad1Out), .pad1Oe(pad1Oe), .rxLine(rxLine)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) divQ <= 0;
    else divQ <= (divQ == P - 1) ? 0 : divQ + 1;
  end
  assign baudTick = (divQ == P - 1);
  assign txPin = swapPins ? pad1Out : pad0Out;

  always @(negedge clk) begin
    if (rstN && txDone) doneCnt++;
    if (rstN && txIrq) irqCnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkNear(input string req, input int act, input int exp, input int tol);
    check((act >= exp - tol) && (act <= exp + tol), req, act, exp);
  endtask

  task automatic waitLevel(input logic v);
    while (txPin !== v) @(negedge clk);
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    txData = b;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic tReset;
    check(pad0Out == 1'b1, "R3 idle high after reset", pad0Out, 1);
    check(pad0Oe == 1'b1 && pad1Oe == 1'b0, "R7 pad0 transmits after reset", pad1Oe, 0);
    check(txDone == 1'b0 && breakBusy == 1'b0, "R5/R4 quiet after reset", txDone, 0);
    check(txReady == 1'b0, "R2 not ready when disabled", txReady, 0);
  endtask

  task automatic tDisabled;
    int lows = 0;
    int rdy = 0;
    txEnable = 1'b0;
    txData = 8'h00;
    txValid = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (txPin == 1'b0) lows++;
      if (txReady) rdy++;
    end
    txValid = 1'b0;
    check(lows == 0, "R2 line low while disabled", lows, 0);
    check(rdy == 0, "R2 ready while disabled", rdy, 0);
  endtask

  task automatic tFrame(input logic [7:0] b);
    logic [7:0] got = 8'h00;
    fork
      pushByte(b);
      begin
        waitLevel(1'b0);
        repeat (8 * P) @(negedge clk);
        check(txPin == 1'b0, "R3 start bit low", txPin, 0);
        check(txReady == 1'b0, "R9 not ready mid frame", txReady, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (16 * P) @(negedge clk);
          got[i] = txPin;
        end
        repeat (16 * P) @(negedge clk);
        check(txPin == 1'b1, "R3 stop high", txPin, 1);
      end
    join
    check(got == b, "R3 data bits LSB first", got, b);
    repeat (20 * P) @(negedge clk);
  endtask

  task automatic tStop(input logic [1:0] sel, input int halves);
    int t1 = 0;
    int t2 = 0;
    int d0 = doneCnt;
    stopSel = sel;
    fork
      begin
        pushByte(8'h35);
        pushByte(8'h4A);
      end
      begin
        waitLevel(1'b0);
        t1 = cyc;
        while (cyc < t1 + 144 * P + 3) @(negedge clk);
        waitLevel(1'b0);
        t2 = cyc;
      end
    join
    checkNear("R1 stop length between frames", t2 - t1, (144 + halves * 8) * P, 4);
    repeat (200 * P) @(negedge clk);
    check(doneCnt - d0 == 1, "R8 single done over chained frames", doneCnt - d0, 1);
    stopSel = 2'b00;
  endtask

  task automatic tDoneIrq;
    int d0 = doneCnt;
    int i0 = irqCnt;
    doneIe = 1'b1;
    pushByte(8'h5A);
    repeat (200 * P) @(negedge clk);
    check(doneCnt - d0 == 1, "R5 done pulse after frame", doneCnt - d0, 1);
    check(irqCnt - i0 == 1, "R6 irq with enable", irqCnt - i0, 1);
    doneIe = 1'b0;
    d0 = doneCnt;
    i0 = irqCnt;
    pushByte(8'hA5);
    repeat (200 * P) @(negedge clk);
    check(doneCnt - d0 == 1, "R5 done pulse second frame", doneCnt - d0, 1);
    check(irqCnt - i0 == 0, "R6 irq masked", irqCnt - i0, 0);
  endtask

  task automatic tBreak;
    int t1 = 0;
    int t2 = 0;
    int t3 = 0;
    int d0 = doneCnt;
    stopSel = 2'b10;
    @(negedge clk) breakSet = 1'b1;
    @(negedge clk) breakSet = 1'b0;
    check(breakBusy == 1'b1, "R4 break flag set", breakBusy, 1);
    check(txReady == 1'b0, "R9 not ready with break pending", txReady, 0);
    waitLevel(1'b0);
    t1 = cyc;
    waitLevel(1'b1);
    t2 = cyc;
    checkNear("R4 break low length", t2 - t1, (144 + 32) * P, 4);
    while (breakBusy) @(negedge clk);
    t3 = cyc;
    checkNear("R4 flag clears after high bit", t3 - t2, 16 * P, 4);
    repeat (4) @(negedge clk);
    check(doneCnt - d0 == 1, "R5 done after break", doneCnt - d0, 1);
    stopSel = 2'b00;
  endtask

  task automatic tSwap;
    swapPins = 1'b1;
    pad0In = 1'b0;
    pad1In = 1'b1;
    @(negedge clk);
    check(pad1Oe == 1'b1 && pad0Oe == 1'b0, "R7 swapped enables", pad1Oe, 1);
    check(rxLine == 1'b0, "R7 rx from pad0 when swapped", rxLine, 0);
    check(pad0Out == 1'b1, "R7 idle pad drives high", pad0Out, 1);
    tFrame(8'hC3);
    swapPins = 1'b0;
    pad0In = 1'b1;
    pad1In = 1'b0;
    @(negedge clk);
    check(rxLine == 1'b0 && pad0Oe == 1'b1, "R7 rx from pad1 unswapped", rxLine, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    tReset;
    tDisabled;
    txEnable = 1'b1;
    tFrame(8'hA5);
    tFrame(8'h3C);
    tStop(2'b00, 2);
    tStop(2'b01, 1);
    tStop(2'b10, 4);
    tStop(2'b11, 3);
    tDoneIrq;
    tBreak;
    tSwap;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule